// File: doc/BRIEF.md
# Pipelined Planar Gravity Force Unit

This block computes the planar gravitational pull that one reference body exerts on a stream of other bodies. Each cycle it can accept one streamed body, given as x position, y position and mass. It returns the x and y force increments for that body after a fixed delay. The reference position and reference mass are plain inputs that the block samples on the same edge as the body. All values are signed Q8.8, 16 bits wide, and every arithmetic step saturates.

The force expression is mass·dx/r³ and mass·dy/r³. The block evaluates it in one pipeline that never stalls. The square root and the reciprocal are unrolled shift-and-subtract loops, with one register stage for each result bit. A valid bit travels alongside the data. Two saturating accumulators add up the increments. A synchronous clear empties them before a new reference body is processed.

Top module: `gforce_pipe`

## Requirements
- R1: The differences are dx = sat(ref_x − body_x) and dy = sat(ref_y − body_y). sat() clamps to the range −32768..32767 in raw integer units.
- R2: The scaled mass is gm = qmul(ref_m, body_m). qmul(a,b) = sat(floor(a·b / 256)) on the raw values.
- R3: The distance is r = floor(sqrt(dx² + dy²)), computed on raw values. This is the Q8.8 distance.
- R4: The inverse distance is rr = min(floor(65536 / r), 32767) for r ≠ 0.
- R5: The chain is p = qmul(rr, gm), then p = qmul(rr, p), then p = qmul(rr, p), in that order. The results are force_x = qmul(dx, p) and force_y = qmul(dy, p).
- R6: When dx = dy = 0, both force outputs are 0.
- R7: A body sampled with body_valid high on a rising edge appears with force_valid high right after the 39th rising edge, counting the sampling edge as the first. Bodies may arrive on consecutive cycles. force_valid rises only for valid bodies.
- R8: On each cycle with force_valid high and acc_clear low, sum_x and sum_y become sat(sum + force). On cycles with neither, they hold their value.
- R9: acc_clear high on an edge replaces the sums. They become the increment arriving on that edge, or 0 when none arrives.
- R10: After reset, force_valid, force_x, force_y, sum_x and sum_y are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ref_x | input | 16 | Reference x position, Q8.8 |
| ref_y | input | 16 | Reference y position, Q8.8 |
| ref_m | input | 16 | Reference scaled mass, Q8.8 |
| body_x | input | 16 | Streamed body x position, Q8.8 |
| body_y | input | 16 | Streamed body y position, Q8.8 |
| body_m | input | 16 | Streamed body mass, Q8.8 |
| body_valid | input | 1 | Streamed body present this cycle |
| acc_clear | input | 1 | Synchronous clear of both sums |
| force_x | output | 16 | x force increment, Q8.8 |
| force_y | output | 16 | y force increment, Q8.8 |
| force_valid | output | 1 | Force increment present |
| sum_x | output | 16 | Running x sum, Q8.8 |
| sum_y | output | 16 | Running y sum, Q8.8 |

## Verification
A clear and the arrival of a finished increment can land on the same clock edge. In that case the sums must restart from the arriving increment, not from zero and not from the old total. The bench launches a single body and raises acc_clear for exactly the edge on which that body leaves the pipeline. It then compares the sums with the increment, which the bench computes itself. A separate clear with nothing arriving confirms that the sums go to zero.

// File: rtl/gf_pkg.sv
package gf_pkg;
  localparam int DW    = 16;            // data width, Q8.8
  localparam int FRAC  = 8;             // fraction bits
  localparam int SAT_W = 2 * DW + 8;    // headroom for intermediate values
  localparam int RAD_W = 2 * DW;        // squared distance width
  localparam int QUO_W = DW + 1;        // reciprocal quotient width

  typedef logic signed [DW-1:0] q_t;

  // clamp a wide signed value into the data range
  function automatic q_t q_sat(input logic signed [SAT_W-1:0] v);
    if ((&v[SAT_W-1:DW-1]) || !(|v[SAT_W-1:DW-1])) return v[DW-1:0];
    else if (v[SAT_W-1]) return {1'b1, {(DW-1){1'b0}}};
    else return {1'b0, {(DW-1){1'b1}}};
  endfunction

  function automatic logic signed [SAT_W-1:0] q_ext(input q_t a);
    return {{(SAT_W-DW){a[DW-1]}}, a};
  endfunction

  function automatic q_t q_add(input q_t a, input q_t b);
    return q_sat(q_ext(a) + q_ext(b));
  endfunction

  function automatic q_t q_sub(input q_t a, input q_t b);
    return q_sat(q_ext(a) - q_ext(b));
  endfunction

  // fixed-point product, floor rounding
  function automatic q_t q_mul(input q_t a, input q_t b);
    logic signed [2*DW-1:0] prod;
    logic signed [2*DW-1:0] shf;
    prod = a * b;
    shf  = prod >>> FRAC;
    return q_sat({{(SAT_W-2*DW){shf[2*DW-1]}}, shf});
  endfunction

  // clip an unsigned quotient to the largest positive value
  function automatic q_t q_clip(input logic [QUO_W-1:0] q);
    if (q > QUO_W'({1'b0, {(DW-1){1'b1}}})) return {1'b0, {(DW-1){1'b1}}};
    else return q_t'(q[DW-1:0]);
  endfunction
endpackage

// File: rtl/gf_isqrt_pipe.sv
module gf_isqrt_pipe #(
  parameter int RAD_W  = 32,
  parameter int SIDE_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RAD_W-1:0]  rad_i,
  input  logic [SIDE_W-1:0] side_i,
  input  logic              v_i,
  output logic [RAD_W/2-1:0] root_o,
  output logic [SIDE_W-1:0] side_o,
  output logic              v_o
);
  localparam int ROOT_W = RAD_W / 2;
  localparam int REM_W  = ROOT_W + 2;

  logic [RAD_W-1:0]  n_q    [ROOT_W];
  logic [REM_W-1:0]  rem_q  [ROOT_W];
  logic [ROOT_W-1:0] root_q [ROOT_W];
  logic [SIDE_W-1:0] side_q [ROOT_W];
  logic              v_q    [ROOT_W];

  for (genvar i = 0; i < ROOT_W; i++) begin : g_stage
    logic [RAD_W-1:0]  n_in;
    logic [REM_W-1:0]  rem_in;
    logic [ROOT_W-1:0] root_in;
    logic [SIDE_W-1:0] side_in;
    logic              v_in;
    logic [REM_W-1:0]  rem_sh;
    logic [REM_W-1:0]  trial;
    logic              take;

    if (i == 0) begin : g_first
      assign n_in    = rad_i;
      assign rem_in  = '0;
      assign root_in = '0;
      assign side_in = side_i;
      assign v_in    = v_i;
    end else begin : g_rest
      assign n_in    = n_q[i-1];
      assign rem_in  = rem_q[i-1];
      assign root_in = root_q[i-1];
      assign side_in = side_q[i-1];
      assign v_in    = v_q[i-1];
    end

    // bring down two radicand bits, try subtracting 4*root+1
    assign rem_sh = {rem_in[REM_W-3:0], n_in[RAD_W-1 -: 2]};
    assign trial  = {root_in, 2'b01};
    assign take   = (rem_sh >= trial);

    always_ff @(posedge clk) begin
      if (rst) v_q[i] <= 1'b0;
      else     v_q[i] <= v_in;
      n_q[i]    <= n_in << 2;
      rem_q[i]  <= take ? (rem_sh - trial) : rem_sh;
      root_q[i] <= {root_in[ROOT_W-2:0], take};
      side_q[i] <= side_in;
    end
  end

  assign root_o = root_q[ROOT_W-1];
  assign side_o = side_q[ROOT_W-1];
  assign v_o    = v_q[ROOT_W-1];
endmodule

// File: rtl/gf_recip_pipe.sv
module gf_recip_pipe #(
  parameter int DIV_W  = 16,
  parameter int QUO_W  = 17,
  parameter int SIDE_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  den_i,
  input  logic [SIDE_W-1:0] side_i,
  input  logic              v_i,
  output logic [QUO_W-1:0]  quo_o,
  output logic [DIV_W-1:0]  den_o,
  output logic [SIDE_W-1:0] side_o,
  output logic              v_o
);
  localparam int REM_W = DIV_W + 1;
  localparam int CHK_W = QUO_W + DIV_W + 2;

  logic [REM_W-1:0]  rem_q  [QUO_W];
  logic [QUO_W-1:0]  quo_q  [QUO_W];
  logic [DIV_W-1:0]  den_q  [QUO_W];
  logic [SIDE_W-1:0] side_q [QUO_W];
  logic              v_q    [QUO_W];

  // dividend is a single one followed by QUO_W-1 zeros: bit i is constant
  for (genvar i = 0; i < QUO_W; i++) begin : g_stage
    localparam logic DBIT = (i == 0);
    logic [REM_W-1:0]  rem_in;
    logic [QUO_W-1:0]  quo_in;
    logic [DIV_W-1:0]  den_in;
    logic [SIDE_W-1:0] side_in;
    logic              v_in;
    logic [REM_W-1:0]  rem_sh;
    logic              take;

    if (i == 0) begin : g_first
      assign rem_in  = '0;
      assign quo_in  = '0;
      assign den_in  = den_i;
      assign side_in = side_i;
      assign v_in    = v_i;
    end else begin : g_rest
      assign rem_in  = rem_q[i-1];
      assign quo_in  = quo_q[i-1];
      assign den_in  = den_q[i-1];
      assign side_in = side_q[i-1];
      assign v_in    = v_q[i-1];
    end

    assign rem_sh = {rem_in[REM_W-2:0], DBIT};
    assign take   = (rem_sh >= {1'b0, den_in});

    always_ff @(posedge clk) begin
      if (rst) v_q[i] <= 1'b0;
      else     v_q[i] <= v_in;
      rem_q[i]  <= take ? (rem_sh - {1'b0, den_in}) : rem_sh;
      quo_q[i]  <= {quo_in[QUO_W-2:0], take};
      den_q[i]  <= den_in;
      side_q[i] <= side_in;
    end
  end

  assign quo_o  = quo_q[QUO_W-1];
  assign den_o  = den_q[QUO_W-1];
  assign side_o = side_q[QUO_W-1];
  assign v_o    = v_q[QUO_W-1];

  // quotient brackets the true reciprocal: q*d <= 2^(QUO_W-1) < (q+1)*d
  logic [CHK_W-1:0] chk_lo, chk_hi, chk_one;
  assign chk_lo  = CHK_W'(quo_o) * CHK_W'(den_o);
  assign chk_hi  = chk_lo + CHK_W'(den_o);
  assign chk_one = CHK_W'(1) << (QUO_W - 1);

  assert_recip_bounds_R4: assert property (@(posedge clk) disable iff (rst)
    (v_o && den_o != '0) |-> (chk_lo <= chk_one && chk_hi > chk_one));
endmodule

// File: rtl/gf_accum.sv
module gf_accum
  import gf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc_v,
  input  q_t   inc,
  output q_t   sum
);
  always_ff @(posedge clk) begin
    if (rst)        sum <= '0;
    else if (clr)   sum <= inc_v ? inc : '0;
    else if (inc_v) sum <= q_add(sum, inc);
  end

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (clr && !inc_v) |=> (sum == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc_v) |=> $stable(sum));
endmodule

// File: rtl/gforce_pipe.sv
module gforce_pipe
  import gf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] ref_x,
  input  logic [15:0] ref_y,
  input  logic [15:0] ref_m,
  input  logic [15:0] body_x,
  input  logic [15:0] body_y,
  input  logic [15:0] body_m,
  input  logic        body_valid,
  input  logic        acc_clear,
  output logic [15:0] force_x,
  output logic [15:0] force_y,
  output logic        force_valid,
  output logic [15:0] sum_x,
  output logic [15:0] sum_y
);
  localparam int SIDE_W = 3 * DW;   // {gm, dx, dy}
  localparam int MUL_N  = 3;        // rr multiplies applied to gm
  localparam int CHK_W  = RAD_W + 2;

  // stage A: differences and scaled mass
  q_t dx_a, dy_a, gm_a;
  logic v_a;
  always_ff @(posedge clk) begin
    if (rst) v_a <= 1'b0;
    else     v_a <= body_valid;
    dx_a <= q_sub(q_t'(ref_x), q_t'(body_x));
    dy_a <= q_sub(q_t'(ref_y), q_t'(body_y));
    gm_a <= q_mul(q_t'(ref_m), q_t'(body_m));
  end

  // stage B: squared distance
  logic signed [2*DW-1:0] sqx_a, sqy_a;
  logic [RAD_W-1:0]  r2_b;
  logic [SIDE_W-1:0] side_b;
  logic v_b;
  assign sqx_a = dx_a * dx_a;
  assign sqy_a = dy_a * dy_a;
  always_ff @(posedge clk) begin
    if (rst) v_b <= 1'b0;
    else     v_b <= v_a;
    r2_b   <= $unsigned(sqx_a) + $unsigned(sqy_a);
    side_b <= {gm_a, dx_a, dy_a};
  end

  // square root
  logic [DW-1:0]     root_s;
  logic [SIDE_W-1:0] side_s;
  logic v_s;
  gf_isqrt_pipe #(.RAD_W(RAD_W), .SIDE_W(SIDE_W)) u_sqrt (
    .clk(clk), .rst(rst), .rad_i(r2_b), .side_i(side_b), .v_i(v_b),
    .root_o(root_s), .side_o(side_s), .v_o(v_s));

  // reciprocal
  logic [QUO_W-1:0]  quo_r;
  logic [DW-1:0]     den_r;
  logic [SIDE_W-1:0] side_r;
  logic v_r;
  gf_recip_pipe #(.DIV_W(DW), .QUO_W(QUO_W), .SIDE_W(SIDE_W)) u_recip (
    .clk(clk), .rst(rst), .den_i(root_s), .side_i(side_s), .v_i(v_s),
    .quo_o(quo_r), .den_o(den_r), .side_o(side_r), .v_o(v_r));

  // gm * rr^3, one multiply per stage
  q_t   p_q  [MUL_N];
  q_t   rr_q [MUL_N];
  q_t   dx_q [MUL_N];
  q_t   dy_q [MUL_N];
  logic v_q  [MUL_N];

  for (genvar k = 0; k < MUL_N; k++) begin : g_mul
    q_t p_in, rr_in, dx_in, dy_in;
    logic v_in;
    if (k == 0) begin : g_first
      assign p_in  = side_r[3*DW-1 -: DW];
      assign rr_in = q_clip(quo_r);
      assign dx_in = side_r[2*DW-1 -: DW];
      assign dy_in = side_r[DW-1:0];
      assign v_in  = v_r;
    end else begin : g_rest
      assign p_in  = p_q[k-1];
      assign rr_in = rr_q[k-1];
      assign dx_in = dx_q[k-1];
      assign dy_in = dy_q[k-1];
      assign v_in  = v_q[k-1];
    end
    always_ff @(posedge clk) begin
      if (rst) v_q[k] <= 1'b0;
      else     v_q[k] <= v_in;
      p_q[k]  <= q_mul(rr_in, p_in);
      rr_q[k] <= rr_in;
      dx_q[k] <= dx_in;
      dy_q[k] <= dy_in;
    end
  end

  // final stage: force increments
  q_t   p3, dx3, dy3, fx_n, fy_n;
  logic v3, coincident;
  assign p3         = p_q[MUL_N-1];
  assign dx3        = dx_q[MUL_N-1];
  assign dy3        = dy_q[MUL_N-1];
  assign v3         = v_q[MUL_N-1];
  assign coincident = (dx3 == '0) && (dy3 == '0);
  assign fx_n       = coincident ? '0 : q_mul(dx3, p3);
  assign fy_n       = coincident ? '0 : q_mul(dy3, p3);

  always_ff @(posedge clk) begin
    if (rst) begin
      force_valid <= 1'b0;
      force_x     <= '0;
      force_y     <= '0;
    end else begin
      force_valid <= v3;
      if (v3) begin
        force_x <= fx_n;
        force_y <= fy_n;
      end
    end
  end

  q_t sum_x_q, sum_y_q;
  gf_accum u_acc_x (.clk(clk), .rst(rst), .clr(acc_clear), .inc_v(v3),
                    .inc(fx_n), .sum(sum_x_q));
  gf_accum u_acc_y (.clk(clk), .rst(rst), .clr(acc_clear), .inc_v(v3),
                    .inc(fy_n), .sum(sum_y_q));
  assign sum_x = sum_x_q;
  assign sum_y = sum_y_q;

  // assertion support: root brackets the distance rebuilt from the sideband
  q_t dx_s, dy_s;
  logic signed [2*DW-1:0] chk_dx2, chk_dy2;
  logic [CHK_W-1:0] chk_r2, chk_lo, chk_hi;
  assign dx_s    = side_s[2*DW-1 -: DW];
  assign dy_s    = side_s[DW-1:0];
  assign chk_dx2 = dx_s * dx_s;
  assign chk_dy2 = dy_s * dy_s;
  assign chk_r2  = CHK_W'($unsigned(chk_dx2)) + CHK_W'($unsigned(chk_dy2));
  assign chk_lo  = CHK_W'(root_s) * CHK_W'(root_s);
  assign chk_hi  = (CHK_W'(root_s) + 1'b1) * (CHK_W'(root_s) + 1'b1);

  assert_root_bounds_R3: assert property (@(posedge clk) disable iff (rst)
    v_s |-> (chk_lo <= chk_r2 && chk_hi > chk_r2));

  assert_zero_force_R6: assert property (@(posedge clk) disable iff (rst)
    (v3 && coincident) |=> (force_valid && force_x == '0 && force_y == '0));

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
    v3 |=> force_valid);

  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !v3 |=> !force_valid);
endmodule

// File: tb/gforce_pipe_tb.sv
module gforce_pipe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 39;
  localparam int NVEC       = 10;
  localparam int MAXQ       = 64;

  // {ref_x, ref_y, ref_m, body_x, body_y, body_m}
  localparam logic [95:0] VEC [NVEC] = '{
    96'h0000_0000_0100_0300_0400_0100,
    96'h0100_0200_0080_0100_0200_0300,
    96'h7FFF_8000_7FFF_8000_7FFF_7FFF,
    96'h0001_0000_7FFF_0000_0000_0100,
    96'h0000_0000_0200_FF00_0080_FF00,
    96'h0A00_F600_0300_0000_0000_0040,
    96'h0010_0020_1000_0000_0000_0800,
    96'h0100_0000_7FFF_0000_0000_0100,
    96'h0100_0000_7FFF_0000_0000_0100,
    96'hFF00_0000_7FFF_0000_0000_0100
  };

  logic clk = 0, rst = 1;
  logic [15:0] ref_x = 0, ref_y = 0, ref_m = 0, body_x = 0, body_y = 0, body_m = 0;
  logic body_valid = 0, acc_clear = 0;
  logic [15:0] force_x, force_y, sum_x, sum_y;
  logic force_valid;

  gforce_pipe dut_i (.clk(clk), .rst(rst), .ref_x(ref_x), .ref_y(ref_y), .ref_m(ref_m),
    .body_x(body_x), .body_y(body_y), .body_m(body_m), .body_valid(body_valid),
    .acc_clear(acc_clear), .force_x(force_x), .force_y(force_y),
    .force_valid(force_valid), .sum_x(sum_x), .sum_y(sum_y));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, n_sent = 0, n_got = 0;
  bit done = 0, mon_on = 0, clr_prev = 0;
  longint exp_fx [MAXQ], exp_fy [MAXQ];
  int launch [MAXQ];
  longint mod_sx = 0, mod_sy = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint bsat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction
  function automatic longint bmul(input longint a, input longint b);
    return bsat((a * b) >>> 8);
  endfunction
  function automatic longint bsqrt(input longint n);
    longint r = 0;
    for (int b = 15; b >= 0; b--) begin
      longint c = r + (longint'(1) << b);
      if (c * c <= n) r = c;
    end
    return r;
  endfunction
  function automatic longint sx(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [95:0] v);
    longint dx, dy, gm, r, rr, p;
    @(posedge clk); #1;
    {ref_x, ref_y, ref_m, body_x, body_y, body_m} = v;
    body_valid = 1;
    dx = bsat(sx(v[95:80]) - sx(v[47:32]));          // R1
    dy = bsat(sx(v[79:64]) - sx(v[31:16]));
    gm = bmul(sx(v[63:48]), sx(v[15:0]));            // R2
    r  = bsqrt(dx * dx + dy * dy);                   // R3
    if (r == 0) begin                                // R6
      exp_fx[n_sent] = 0; exp_fy[n_sent] = 0;
    end else begin
      rr = 65536 / r; if (rr > 32767) rr = 32767;    // R4
      p = bmul(rr, gm); p = bmul(rr, p); p = bmul(rr, p);  // R5
      exp_fx[n_sent] = bmul(dx, p);
      exp_fy[n_sent] = bmul(dy, p);
    end
    launch[n_sent] = cyc;
    n_sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; body_valid = 0;
    end
  endtask

  // monitor: sees the values left by the previous rising edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (force_valid) begin
        if (n_got >= n_sent) begin
          check(0, "R7 spurious valid", n_got, n_sent);
        end else begin
          check(sx(force_x) == exp_fx[n_got], "R5/R6 force_x", sx(force_x), exp_fx[n_got]);
          check(sx(force_y) == exp_fy[n_got], "R5/R6 force_y", sx(force_y), exp_fy[n_got]);
          check(cyc - launch[n_got] == LAT, "R7 latency", cyc - launch[n_got], LAT);
          if (clr_prev) begin                         // R9 clear meets arrival
            mod_sx = exp_fx[n_got]; mod_sy = exp_fy[n_got];
          end else begin                              // R8 accumulate
            mod_sx = bsat(mod_sx + exp_fx[n_got]); mod_sy = bsat(mod_sy + exp_fy[n_got]);
          end
          check(sx(sum_x) == mod_sx, "R8/R9 sum_x", sx(sum_x), mod_sx);
          check(sx(sum_y) == mod_sy, "R8/R9 sum_y", sx(sum_y), mod_sy);
          n_got++;
        end
      end else if (clr_prev) begin                    // R9 clear alone
        mod_sx = 0; mod_sy = 0;
        check(sx(sum_x) == 0, "R9 clear sum_x", sx(sum_x), 0);
        check(sx(sum_y) == 0, "R9 clear sum_y", sx(sum_y), 0);
      end
      clr_prev = acc_clear;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1; rst = 0;
    @(negedge clk);
    // R10 reset state
    check(force_valid == 0, "R10 force_valid", force_valid, 0);
    check(force_x == 0 && force_y == 0, "R10 force", sx(force_x), 0);
    check(sum_x == 0 && sum_y == 0, "R10 sums", sx(sum_x), 0);
    mon_on = 1;

    // table walk, back to back bodies
    for (int i = 0; i < NVEC; i++) send(VEC[i]);
    idle(LAT + 4);

    // R9: clear with nothing arriving
    @(posedge clk); #1; acc_clear = 1;
    @(posedge clk); #1; acc_clear = 0;
    idle(2);

    // R9: clear on the same edge as an arriving increment
    send(VEC[0]);
    idle(1);
    repeat (LAT - 2) @(posedge clk);
    #1; acc_clear = 1;
    @(posedge clk); #1; acc_clear = 0;
    idle(4);

    // R8: hold with no input after the clear
    send(VEC[7]);
    idle(LAT + 4);
    check(sx(sum_x) == mod_sx, "R8 hold sum_x", sx(sum_x), mod_sx);

    // R7: every launched body came back exactly once
    check(n_got == n_sent, "R7 count", n_got, n_sent);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule